// File: doc/BRIEF.md
# Segmented Memory Address and Select Unit

This block sits between a 16-bit processor core and its memory blocks. For every access request it forms the physical bus address, checks that the access width and alignment suit the kind of access, and raises the enable of exactly one memory block. The three blocks are the peripheral/special-register window, RAM and program memory. Any block whose range does not hold the address keeps its enable low, which saves power.

The block has an address extension mode. With extension on, an instruction fetch takes a 4-bit code segment pointer as the upper part of the address, in 64 KiB steps, and adds the program counter. A data or stack access picks one of two 8-bit data page pointers, scales it in 16 KiB steps and adds the operand address. With extension off, both pointers are ignored and the address is the plain 16-bit value.

The region decode always looks at the low 16 bits of the physical address, so the same map repeats in every 64 KiB window. Writes to program memory are suppressed and flagged. Accesses to the top sixteen words (vector table) are marked. The result of a request is registered and appears one clock cycle after it.

Top module: `seg_addr_unit`

## Requirements
- R1: While rst_n is low, every output is 0.
- R2: With ext_en=1 and req_fetch=1, phys_addr = code_seg * 0x10000 + req_addr.
- R3: With ext_en=1 and req_fetch=0, phys_addr = P * 0x4000 + req_addr, where P is page0 when page_sel=0 and page1 when page_sel=1.
- R4: With ext_en=0, phys_addr = req_addr with all upper bits 0, whatever code_seg, page0, page1 and page_sel hold.
- R5: For an error-free access, the enable is chosen from the low 16 address bits: en_periph for 0x0000–PER_TOP, en_ram for PER_TOP+1 to RAM_TOP, en_rom for ROM_BASE–0xFFFF. At most one enable is high at any time.
- R6: A low-16 address outside all three ranges sets bus_err and raises no enable.
- R7: A write (req_write=1, req_fetch=0) that lands in program memory sets wr_blocked and raises no enable. Reads and fetches of program memory are allowed. A fetch is always treated as a read.
- R8: vec_hit is 1 exactly when the low 16 address bits are 0xFFE0 or above.
- R9: A word access (req_byte=0) at an odd address sets align_err and raises no enable.
- R10: A fetch or stack access (req_fetch=1 or req_stack=1) with req_byte=1 sets width_err and raises no enable.
- R11: Results appear one cycle after the request. out_valid equals the previous cycle's req_valid. After an idle cycle (req_valid=0), every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_fetch | input | 1 | Instruction fetch (uses code segment) |
| req_stack | input | 1 | Stack access (word only) |
| req_write | input | 1 | Write access |
| req_byte | input | 1 | Byte access, 0 = word |
| req_addr | input | 16 | Program counter or operand address |
| ext_en | input | 1 | Address extension enable |
| code_seg | input | SEG_W (4) | Code segment pointer |
| page0 | input | PAGE_W (8) | Data page pointer 0 |
| page1 | input | PAGE_W (8) | Data page pointer 1 |
| page_sel | input | 1 | Selects page1 when 1 |
| out_valid | output | 1 | Registered result valid |
| phys_addr | output | PA_W (23) | Physical bus address |
| en_periph | output | 1 | Peripheral/special-register enable |
| en_ram | output | 1 | RAM enable |
| en_rom | output | 1 | Program memory enable |
| wr_blocked | output | 1 | Write to program memory suppressed |
| vec_hit | output | 1 | Vector table access |
| align_err | output | 1 | Odd word address |
| width_err | output | 1 | Byte fetch or byte stack access |
| bus_err | output | 1 | Address in no region |

## Verification
The bench sweeps addresses across the whole 16-bit space with an odd stride, plus every region edge and the vector-table boundary. It does this for six access kinds: word fetch, byte fetch, word read, byte write, word write and word stack access. Each combination runs with extension both off and on.

The segment and page pointers change with the address. This shows the difference between the code-segment and data-page formulas, and between the two page pointers. With extension off, the same nonzero pointers must have no effect. The odd addresses hit by the stride separate alignment errors from width errors. Program-memory writes and gap addresses separate the write-blocked case from the bus-error case.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int          SEG_W    = 4,
  parameter int          PAGE_W   = 8,
  parameter logic [15:0] PER_TOP  = 16'h01FF,
  parameter logic [15:0] RAM_TOP  = 16'h09FF,
  parameter logic [15:0] ROM_BASE = 16'hC000,
  localparam int PA_W = (SEG_W + 16 > PAGE_W + 15) ? SEG_W + 16 : PAGE_W + 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_fetch,
  input  logic              req_stack,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [15:0]       req_addr,
  input  logic              ext_en,
  input  logic [SEG_W-1:0]  code_seg,
  input  logic [PAGE_W-1:0] page0,
  input  logic [PAGE_W-1:0] page1,
  input  logic              page_sel,
  output logic              out_valid,
  output logic [PA_W-1:0]   phys_addr,
  output logic              en_periph,
  output logic              en_ram,
  output logic              en_rom,
  output logic              wr_blocked,
  output logic              vec_hit,
  output logic              align_err,
  output logic              width_err,
  output logic              bus_err
);
  localparam logic [15:0] RAM_BASE = PER_TOP + 16'd1;
  localparam logic [15:0] VEC_BASE = 16'hFFE0;

  logic [PAGE_W-1:0] page;
  logic [PA_W-1:0]   flat_pa, code_pa, data_pa, pa_n;
  logic [15:0]       lo;
  logic in_per, in_ram, in_rom, is_wr, w_err, a_err, b_err, blk, ok;

  assign page    = page_sel ? page1 : page0;
  assign flat_pa = {{(PA_W-16){1'b0}}, req_addr};
  assign code_pa = ({{(PA_W-SEG_W){1'b0}}, code_seg} << 16) + flat_pa;
  assign data_pa = ({{(PA_W-PAGE_W){1'b0}}, page} << 14) + flat_pa;
  assign pa_n    = !ext_en ? flat_pa : (req_fetch ? code_pa : data_pa);
  assign lo      = pa_n[15:0];

  assign in_per = lo <= PER_TOP;
  assign in_ram = (lo >= RAM_BASE) && (lo <= RAM_TOP);
  assign in_rom = lo >= ROM_BASE;

  assign is_wr = req_write & ~req_fetch;
  assign w_err = (req_fetch | req_stack) & req_byte;
  assign a_err = ~req_byte & req_addr[0];
  assign b_err = ~(in_per | in_ram | in_rom);
  assign blk   = is_wr & in_rom & ~w_err & ~a_err;
  assign ok    = req_valid & ~(w_err | a_err | b_err | blk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      phys_addr  <= '0;
      en_periph  <= 1'b0;
      en_ram     <= 1'b0;
      en_rom     <= 1'b0;
      wr_blocked <= 1'b0;
      vec_hit    <= 1'b0;
      align_err  <= 1'b0;
      width_err  <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      out_valid  <= req_valid;
      phys_addr  <= req_valid ? pa_n : '0;
      en_periph  <= ok & in_per;
      en_ram     <= ok & in_ram;
      en_rom     <= ok & in_rom;
      wr_blocked <= req_valid & blk;
      vec_hit    <= req_valid & (lo >= VEC_BASE);
      align_err  <= req_valid & a_err;
      width_err  <= req_valid & w_err;
      bus_err    <= req_valid & b_err;
    end
  end

  // R5
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_periph, en_ram, en_rom}));

  // R6
  no_enable_on_buserr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !(en_periph | en_ram | en_rom));

  // R7
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wr_blocked) |-> (!en_rom && $past(req_write) && !$past(req_fetch)));

  // R9
  align_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && align_err) |-> ($past(req_addr[0]) && !$past(req_byte)));

  // R4
  flat_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && !$past(ext_en)) |->
      (phys_addr == {{(PA_W-16){1'b0}}, $past(req_addr)}));

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(req_valid)));

  // R8
  vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit |-> (phys_addr[15:0] >= VEC_BASE));
endmodule

// File: tb/seg_addr_unit_test.sv
module seg_addr_unit_test;
  localparam int PA_W = 23;
  localparam longint PER_TOP = 'h01FF, RAM_TOP = 'h09FF, ROM_BASE = 'hC000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_fetch = 0, req_stack = 0, req_write = 0, req_byte = 0;
  logic [15:0] req_addr = '0;
  logic ext_en = 0, page_sel = 0;
  logic [3:0] code_seg = '0;
  logic [7:0] page0 = '0, page1 = '0;
  logic out_valid, en_periph, en_ram, en_rom, wr_blocked, vec_hit, align_err, width_err, bus_err;
  logic [PA_W-1:0] phys_addr;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  seg_addr_unit uut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(bit f, bit s, bit w, bit b, logic [15:0] a, bit x,
                        logic [3:0] sg, logic [7:0] p0, logic [7:0] p1, bit ps);
    longint pa, lo, pg;
    bit ip, ir, io, we, ae, be, bl, ok;
    req_valid = 1; req_fetch = f; req_stack = s; req_write = w; req_byte = b;
    req_addr = a; ext_en = x; code_seg = sg; page0 = p0; page1 = p1; page_sel = ps;
    pg = ps ? p1 : p0;
    if (!x) pa = a;
    else if (f) pa = sg * 'h10000 + a;
    else pa = pg * 'h4000 + a;
    lo = pa % 'h10000;
    ip = lo <= PER_TOP;
    ir = lo > PER_TOP && lo <= RAM_TOP;
    io = lo >= ROM_BASE;
    we = (f || s) && b;
    ae = !b && a[0];
    be = !(ip || ir || io);
    bl = w && !f && io && !we && !ae;
    ok = !(we || ae || be || bl);
    @(posedge clk); @(negedge clk);
    chk("R11 valid", out_valid, 1);
    chk(!x ? "R4 addr" : (f ? "R2 addr" : "R3 addr"), phys_addr, pa);
    chk("R5 enables", {en_periph, en_ram, en_rom}, {ok && ip, ok && ir, ok && io});
    chk("R6 bus_err", bus_err, be);
    chk("R7 wr_blocked", wr_blocked, bl);
    chk("R8 vec_hit", vec_hit, lo >= 'hFFE0);
    chk("R9 align_err", align_err, ae);
    chk("R10 width_err", width_err, we);
  endtask

  task automatic idle();
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    chk("R11 idle", {out_valid, phys_addr, en_periph, en_ram, en_rom, wr_blocked,
                     vec_hit, align_err, width_err, bus_err}, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL R11 watchdog actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [14] = '{16'h0000, 16'h01FF, 16'h0200, 16'h09FE, 16'h09FF, 16'h0A00,
                                16'hBFFE, 16'hBFFF, 16'hC000, 16'hFFDE, 16'hFFDF, 16'hFFE0,
                                16'hFFFE, 16'hFFFF};
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'hC000;
    @(posedge clk); @(negedge clk);
    // R1 reset clears everything
    chk("R1 reset", {out_valid, phys_addr, en_periph, en_ram, en_rom, wr_blocked,
                     vec_hit, align_err, width_err, bus_err}, 0);
    rst_n = 1;
    for (int x = 0; x < 2; x++) begin
      for (int m = 0; m < 6; m++) begin
        bit f = (m < 2), s = (m == 5), w = (m == 3 || m == 4), b = (m == 1 || m == 3);
        for (int a = 0; a < 65536; a += 'h00F3) begin
          access(f, s, w, b, a[15:0], x[0], a[15:12] ^ 4'h5, a[7:0], ~a[7:0], a[4]);
        end
        foreach (edges[i]) begin
          access(f, s, w, b, edges[i], x[0], 4'(i), 8'(i * 3), 8'hFF, i[0]);
          access(f, s, w, b, edges[i], x[0], 4'hF, 8'h00, 8'(i), 1'b1);
        end
        idle();
      end
    end
    // R3 page select distinguishes pointers on the same operand
    access(0, 0, 0, 0, 16'h0100, 1, 4'h0, 8'h01, 8'h02, 0);
    access(0, 0, 0, 0, 16'h0100, 1, 4'h0, 8'h01, 8'h02, 1);
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule